// File: doc/BRIEF.md
# Multi-Port Hardware Lock Bank

This block keeps a bank of ownership flags that several processor cores share to guard common resources. Each core, plus one host, reaches the bank through its own side port. A transfer on a port carries a device-select byte, a direction bit and a 32-bit register word. A read transfer is a single acquire attempt. It performs an atomic test-and-set on the flag named in the word, and on the next cycle it returns a status word whose bit 24 tells whether the caller now owns the flag. A write transfer releases the named flag. Writes return nothing.

Requests are accepted every cycle with no back-pressure, so the request side needs no ready signal. The response side is a one-cycle valid pulse that the requester must take when it appears, because the block never holds a response. Software on a core spins by issuing acquire reads until the status bit comes back set. It releases the flag with a write once its critical section is done.

Top module: `lkb_top`

## Requirements
- R1: The bank holds NUM_FLAGS (default 64) independent flags, indexed 0 to 63. An operation on one flag never changes another, and ports that acquire different free flags in the same cycle all succeed.
- R2: A transfer counts only when its device-select byte equals DEV_CODE (default 0x90). Any other code produces no response and leaves every flag unchanged.
- R3: The flag index is taken from bits 5:0 of the request word. Bits 7:6 and bits 31:8 are ignored, so an id byte of 0xC7 names flag 7 and 0x7F names flag 63.
- R4: A read transfer (write bit 0) on a free flag sets the flag and returns status 1 in bit 24 of the response word. On a set flag, it returns status 0 and leaves the flag set, including when the current owner makes the request.
- R5: A write transfer (write bit 1) clears the named flag and produces no response. Releasing a flag that is already free has no effect.
- R6: For each port, the response valid rises exactly in the cycle after an accepted read transfer and lasts one cycle. Requests are never stalled.
- R7: When several ports try to acquire the same free flag in the same cycle, only the lowest-numbered port is granted. The others get status 0.
- R8: When a release and an acquire of the same flag arrive in the same cycle, the release takes effect first, so the acquire is granted.
- R9: Reset clears all flags and all response valids. Every response word bit other than bit 24 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | NUM_PORTS | Per-port request valid |
| req_wr_i | input | NUM_PORTS | Per-port direction: 1 release, 0 acquire |
| req_dev_i | input | NUM_PORTS*8 | Per-port device-select byte |
| req_word_i | input | NUM_PORTS*32 | Per-port register word; flag id in bits 5:0 |
| rsp_vld_o | output | NUM_PORTS | Per-port response valid, one cycle after an acquire |
| rsp_word_o | output | NUM_PORTS*32 | Per-port status word; grant in bit 24 |

## Verification
The acquire path is driven with a single port on a free flag, with an acquire on a held flag, and with a repeat attempt by the owner, which separates a true test-and-set from a plain set. Three-way and two-way races on one free flag show whether priority goes to the lowest port. A release paired with an acquire on the same flag in one cycle exposes the order in which the two are applied. Foreign device codes, ids with bits 7:6 set, release of a free flag and mid-run reset are each followed by an acquire through a normal port, so that any hidden change to flag state appears in the status bit.

// File: rtl/lkb_pkg.sv
package lkb_pkg;
  localparam int DEV_W    = 8;
  localparam int WORD_W   = 32;
  localparam int ID_BYTE  = 8;
  localparam int STAT_BIT = 24;
  localparam logic [DEV_W-1:0] LOCK_DEV = 8'h90;
endpackage

// File: rtl/lkb_decode.sv
module lkb_decode import lkb_pkg::*; #(
  parameter int ID_W = 6,
  parameter logic [DEV_W-1:0] DEV_CODE = LOCK_DEV
) (
  input  logic              vld_i,
  input  logic              wr_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              acq_o,
  output logic              rel_o,
  output logic [ID_W-1:0]   id_o
);
  logic hit;
  logic word_unused;

  assign hit         = vld_i && (dev_i == DEV_CODE);
  assign acq_o       = hit && !wr_i;
  assign rel_o       = hit && wr_i;
  assign id_o        = word_i[ID_W-1:0];
  assign word_unused = ^word_i[WORD_W-1:ID_W];
endmodule

// File: rtl/lkb_arbiter.sv
module lkb_arbiter #(
  parameter int NUM_PORTS = 3,
  parameter int NUM_FLAGS = 64,
  localparam int ID_W = $clog2(NUM_FLAGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS-1:0]            acq_i,
  input  logic [NUM_PORTS-1:0]            rel_i,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]  id_i,
  input  logic [NUM_FLAGS-1:0]            flag_i,
  output logic [NUM_PORTS-1:0]            grant_o,
  output logic [NUM_FLAGS-1:0]            rel_mask_o,
  output logic [NUM_FLAGS-1:0]            set_mask_o
);
  logic [NUM_FLAGS-1:0] free_eff;
  logic [NUM_PORTS-1:0] blocked;

  always_comb begin
    rel_mask_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rel_i[p]) rel_mask_o[id_i[p]] = 1'b1;
  end

  assign free_eff = ~flag_i | rel_mask_o;

  always_comb begin
    blocked = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int q = 0; q < NUM_PORTS; q++)
        if (q < p && acq_i[q] && id_i[q] == id_i[p]) blocked[p] = 1'b1;
  end

  always_comb begin
    grant_o    = '0;
    set_mask_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      grant_o[p] = acq_i[p] && free_eff[id_i[p]] && !blocked[p];
      if (grant_o[p]) set_mask_o[id_i[p]] = 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_win_p
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_win_q
      AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o[p] && grant_o[q] && id_i[p] == id_i[q])); // R7
    end
  end
endmodule

// File: rtl/lkb_flags.sv
module lkb_flags #(
  parameter int NUM_FLAGS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] rel_mask_i,
  input  logic [NUM_FLAGS-1:0] set_mask_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~rel_mask_i) | set_mask_i;
  end

  AST_SET_WINS_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask_i & ~rel_mask_i & flag_o) == '0); // R4
endmodule

// File: rtl/lkb_top.sv
module lkb_top import lkb_pkg::*; #(
  parameter int NUM_PORTS = 3,
  parameter int NUM_FLAGS = 64,
  parameter logic [DEV_W-1:0] DEV_CODE = LOCK_DEV
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_vld_i,
  input  logic [NUM_PORTS-1:0]        req_wr_i,
  input  logic [NUM_PORTS*DEV_W-1:0]  req_dev_i,
  input  logic [NUM_PORTS*WORD_W-1:0] req_word_i,
  output logic [NUM_PORTS-1:0]        rsp_vld_o,
  output logic [NUM_PORTS*WORD_W-1:0] rsp_word_o
);
  localparam int ID_W = $clog2(NUM_FLAGS);

  logic [NUM_PORTS-1:0]           acq, rel, grant;
  logic [NUM_PORTS-1:0][ID_W-1:0] id;
  logic [NUM_FLAGS-1:0]           flag_q, rel_mask, set_mask;
  logic [NUM_PORTS-1:0]           rsp_vld_q, rsp_stat_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lkb_decode #(.ID_W(ID_W), .DEV_CODE(DEV_CODE)) u_dec (
      .vld_i  (req_vld_i[p]),
      .wr_i   (req_wr_i[p]),
      .dev_i  (req_dev_i[p*DEV_W +: DEV_W]),
      .word_i (req_word_i[p*WORD_W +: WORD_W]),
      .acq_o  (acq[p]),
      .rel_o  (rel[p]),
      .id_o   (id[p])
    );

    assign rsp_word_o[p*WORD_W +: WORD_W] = WORD_W'(rsp_stat_q[p]) << STAT_BIT;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o[p] |-> $past(req_vld_i[p] && !req_wr_i[p]
                             && req_dev_i[p*DEV_W +: DEV_W] == DEV_CODE)); // R6
    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld_i[p] && req_dev_i[p*DEV_W +: DEV_W] != DEV_CODE) |=> !rsp_vld_o[p]); // R2
    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      grant[p] |=> flag_q[$past(id[p])]); // R4
    AST_RSP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_word_o[p*WORD_W +: WORD_W] & ~(WORD_W'(1) << STAT_BIT)) == '0); // R9
  end

  lkb_arbiter #(.NUM_PORTS(NUM_PORTS), .NUM_FLAGS(NUM_FLAGS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_i      (acq),
    .rel_i      (rel),
    .id_i       (id),
    .flag_i     (flag_q),
    .grant_o    (grant),
    .rel_mask_o (rel_mask),
    .set_mask_o (set_mask)
  );

  lkb_flags #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_mask_i (rel_mask),
    .set_mask_i (set_mask),
    .flag_o     (flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_q  <= '0;
      rsp_stat_q <= '0;
    end else begin
      rsp_vld_q  <= acq;
      rsp_stat_q <= grant;
    end
  end

  assign rsp_vld_o = rsp_vld_q;
endmodule

// File: tb/lkb_top_tb_top.sv
module lkb_top_tb_top;
  import lkb_pkg::*;
  localparam int NP = 3;
  localparam int NV = 20;
  localparam logic [17:0] I = 18'd0;

  function automatic logic [17:0] pa(input logic [7:0] idb);
    return {1'b1, 1'b0, 8'h90, idb};
  endfunction
  function automatic logic [17:0] pr(input logic [7:0] idb);
    return {1'b1, 1'b1, 8'h90, idb};
  endfunction
  function automatic logic [17:0] pf(input logic [7:0] d, input logic w, input logic [7:0] idb);
    return {1'b1, w, d, idb};
  endfunction

  // {port2, port1, port0, expected valid[2:0], expected status[2:0]}
  localparam logic [59:0] VEC [NV] = '{
    {I, I, pa(8'd5), 3'b001, 3'b001},                          // R4 free -> granted
    {I, pa(8'd5), I, 3'b010, 3'b000},                          // R4 held -> refused
    {I, I, pa(8'd5), 3'b001, 3'b000},                          // R4 owner retry refused
    {I, pa(8'd5), pr(8'd5), 3'b010, 3'b010},                   // R8 release first
    {pa(8'd9), pa(8'd9), pa(8'd9), 3'b111, 3'b001},            // R7 port 0 wins
    {pf(8'h91, 1'b0, 8'd9), I, I, 3'b000, 3'b000},             // R2 foreign acquire
    {I, pf(8'h80, 1'b1, 8'd9), I, 3'b000, 3'b000},             // R2 foreign release
    {pa(8'd9), I, I, 3'b100, 3'b000},                          // R2 flag 9 still held
    {pa(8'hC7), I, I, 3'b100, 3'b100},                         // R3 id 0xC7 -> 7
    {I, I, pa(8'd7), 3'b001, 3'b000},                          // R3 flag 7 held
    {I, I, pr(8'd20), 3'b000, 3'b000},                         // R5 release free, silent
    {I, pa(8'd20), I, 3'b010, 3'b010},                         // R5 still free
    {pa(8'd63), I, I, 3'b100, 3'b100},                         // R1 top flag
    {I, I, pr(8'h7F), 3'b000, 3'b000},                         // R3 id 0x7F -> 63
    {I, I, pa(8'd63), 3'b001, 3'b001},                         // R3 63 was released
    {I, pa(8'd1), pa(8'd0), 3'b011, 3'b011},                   // R1 independent flags
    {pr(8'd9), I, I, 3'b000, 3'b000},                          // R5 release 9
    {I, pa(8'd9), I, 3'b010, 3'b010},                          // R5 9 now free
    {pa(8'd30), pa(8'd30), I, 3'b110, 3'b010},                 // R7 port 1 beats port 2
    {I, pr(8'd30), pa(8'd30), 3'b001, 3'b001}                  // R8 release then acquire
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        req_vld = '0, req_wr = '0;
  logic [NP*DEV_W-1:0]  req_dev = '0;
  logic [NP*WORD_W-1:0] req_word = '0;
  logic [NP-1:0]        rsp_vld;
  logic [NP*WORD_W-1:0] rsp_word;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string vreq [NV];

  always #4 clk = ~clk;

  lkb_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld_i  (req_vld),
    .req_wr_i   (req_wr),
    .req_dev_i  (req_dev),
    .req_word_i (req_word),
    .rsp_vld_o  (rsp_vld),
    .rsp_word_o (rsp_word)
  );

  task automatic drive(input logic [53:0] ins);
    for (int p = 0; p < NP; p++) begin
      logic [17:0] f;
      f = ins[p*18 +: 18];
      req_vld[p]              = f[17];
      req_wr[p]               = f[16];
      req_dev[p*8 +: 8]       = f[15:8];
      req_word[p*32 +: 32]    = {24'hC3A55A, f[7:0]};
    end
  endtask

  task automatic check(input string rq, input logic [2:0] ev, input logic [2:0] es);
    logic [NP*WORD_W-1:0] ew;
    for (int p = 0; p < NP; p++)
      ew[p*32 +: 32] = {7'b0, ev[p] & es[p], 24'b0};
    n_chk++;
    if (rsp_vld !== ev || rsp_word !== ew) begin
      n_bad++;
      $display("FAIL %s: valid=%b word=%h expected valid=%b word=%h", rq, rsp_vld, rsp_word, ev, ew);
    end
  endtask

  task automatic step(input logic [53:0] ins, input string rq, input logic [2:0] ev, input logic [2:0] es);
    @(negedge clk);
    drive(ins);
    @(negedge clk);
    check(rq, ev, es);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", 3'b000, 3'b000);
    rst_n = 1'b1;
  endtask

  initial begin
    vreq = '{"R4", "R4", "R4", "R8", "R7", "R2", "R2", "R2", "R3", "R3",
             "R5", "R5", "R1", "R3", "R3", "R1", "R5", "R5", "R7", "R8"};
    repeat (3) @(negedge clk);
    check("R9", 3'b000, 3'b000);               // R9 outputs during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 3'b000, 3'b000);               // R9 idle after reset

    for (int i = 0; i < NV; i++)
      step(VEC[i][59:6], vreq[i], VEC[i][5:3], VEC[i][2:0]);

    // R6: response lasts exactly one cycle
    step({I, I, pa(8'd40)}, "R6", 3'b001, 3'b001);
    step({I, I, I}, "R6", 3'b000, 3'b000);
    // R9: reset frees held flag 40
    pulse_reset();
    step({I, pa(8'd40), I}, "R9", 3'b010, 3'b010);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule